// File: doc/BRIEF.md
# Three-Moduli Residue-to-Binary Converter

This block rebuilds a binary integer from its three residues with respect to the moduli m1 = 2^(2N+1)−1, m2 = 2^(2N) and m3 = 2^(2N)−1. N is a parameter. The product M = m1·m2·m3 sets the dynamic range, and the result is a (6N+1)-bit unsigned number in [0, M). The block sits at the exit of a residue-number datapath, where a value computed channel by channel has to become an ordinary weighted number again.

The block is purely combinational and is built only from adders and selection multiplexers. It uses a mixed-radix decomposition X = d1 + m2·d2 + m2·m1·d3:
- d1 is the m2 residue, taken as it is.
- d2 = 2·(res_a − res_b) mod m1. The factor 2 is the inverse of m2 modulo m1, so the multiplication costs only a one-bit left rotation.
- d3 = (res_c − res_b − d2) mod m3. No multiplier is needed here, because both m2 and m1 are congruent to 1 modulo m3.

Each modulo-(2^k−1) operation is an end-around-carry adder followed by a multiplexer that turns an all-ones sum into zero. The three digit fields do not overlap, so they are packed side by side. One final subtraction then removes the m2·d3 part of the m2·m1·d3 term.

Top module: `rrc_reverse_conv`

## Requirements
- R1: res_a is the residue modulo m1 = 2^(2N+1)−1, res_b the residue modulo m2 = 2^(2N), and res_c the residue modulo m3 = 2^(2N)−1. For every integer X in [0, M) whose residues are applied, x_out equals X. This holds for N = 1, 2 and 3.
- R2: For any input, the low 2N bits of x_out equal res_b.
- R3: For any input, including all-ones codes on res_a or res_c, x_out is below M.
- R4: An all-ones res_a (2^(2N+1)−1) is an alias of zero. It gives the same x_out as res_a = 0 with the other inputs unchanged.
- R5: An all-ones res_c (2^(2N)−1) is an alias of zero. It gives the same x_out as res_c = 0 with the other inputs unchanged.
- R6: All-zero residues give x_out = 0.
- R7: The residues (m1−1, m2−1, m3−1) give x_out = M−1.
- R8: The block has no clock and no storage. A new set of residues is reflected on x_out without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| res_a | input | 2N+1 | Residue modulo 2^(2N+1)−1; all ones reads as zero |
| res_b | input | 2N | Residue modulo 2^(2N) |
| res_c | input | 2N | Residue modulo 2^(2N)−1; all ones reads as zero |
| x_out | output | 6N+1 | Reconstructed binary value in [0, M) |

## Verification
Two functions can act on the same evaluation: the zero-alias fold of an all-ones input, and the wrap of an end-around subtraction when the subtrahend exceeds the minuend. The bench provokes this by applying an all-ones res_a or res_c while res_b carries a large value, so that both digit subtractions wrap. It judges the result by comparing x_out with the output for the same vector with the alias replaced by a true zero. It also checks that the result stays below M and that its low bits still equal res_b.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    // Operation performed by an end-around-carry unit
    typedef enum logic [0:0] {
        EAC_ADD = 1'b0,
        EAC_SUB = 1'b1
    } eac_op_e;

    // Width of the widest residue channel (modulus 2^(2n+1)-1)
    function automatic int wide_w(input int n);
        return 2 * n + 1;
    endfunction

    // Width of the two narrow residue channels
    function automatic int narrow_w(input int n);
        return 2 * n;
    endfunction

    // Width of the reconstructed value
    function automatic int out_w(input int n);
        return 6 * n + 1;
    endfunction

endpackage

// File: rtl/rrc_eac_unit.sv
// Modulo (2^W - 1) adder or subtractor with end-around carry.
// Operands may use the all-ones zero alias; the result never does.
module rrc_eac_unit
    import rrc_pkg::*;
#(
    parameter int      W  = 4,
    parameter eac_op_e OP = EAC_ADD
) (
    input  logic [W-1:0] opd_a,
    input  logic [W-1:0] opd_b,
    output logic [W-1:0] res_y
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] opd_b_eff;
    logic [W:0]   raw_sum;
    logic [W-1:0] wrap_sum;

    generate
        if (OP == EAC_SUB) begin : g_sub
            // one's complement turns subtraction into addition mod 2^W-1
            assign opd_b_eff = ~opd_b;
        end else begin : g_add
            assign opd_b_eff = opd_b;
        end
    endgenerate

    // first carry-propagate pass
    assign raw_sum  = {1'b0, opd_a} + {1'b0, opd_b_eff};
    // carry out re-enters at weight 1 (2^W == 1 mod 2^W-1)
    assign wrap_sum = raw_sum[W-1:0] + {{(W-1){1'b0}}, raw_sum[W]};
    // zero-alias selection
    assign res_y    = (wrap_sum == ALL_ONES) ? '0 : wrap_sum;

endmodule

// File: rtl/rrc_digit_stage.sv
// Mixed-radix digits two and three.
module rrc_digit_stage
    import rrc_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [2*N:0]   res_a,
    input  logic [2*N-1:0] res_b,
    input  logic [2*N-1:0] res_c,
    output logic [2*N:0]   mix_d2,
    output logic [2*N-1:0] mix_d3
);
    localparam int WA = wide_w(N);
    localparam int WB = narrow_w(N);

    logic [WA-1:0] diff_ab;
    logic [WB-1:0] fold_d2;
    logic [WB-1:0] diff_cb;
    logic [WB-1:0] fold_hi;

    // (res_a - res_b) mod 2^(2N+1)-1 ; res_b < that modulus so zero-extend
    rrc_eac_unit #(.W(WA), .OP(EAC_SUB)) u_sub_ab (
        .opd_a (res_a),
        .opd_b ({1'b0, res_b}),
        .res_y (diff_ab)
    );

    // times 2 == inverse of 2^(2N): rotate left by one
    assign mix_d2 = {diff_ab[WA-2:0], diff_ab[WA-1]};

    // reduce d2 modulo 2^(2N)-1: top bit weighs 2^(2N) == 1
    assign fold_hi = {{(WB-1){1'b0}}, mix_d2[WA-1]};

    rrc_eac_unit #(.W(WB), .OP(EAC_ADD)) u_fold_d2 (
        .opd_a (mix_d2[WB-1:0]),
        .opd_b (fold_hi),
        .res_y (fold_d2)
    );

    // res_c - res_b (res_b all ones is the zero alias here)
    rrc_eac_unit #(.W(WB), .OP(EAC_SUB)) u_sub_cb (
        .opd_a (res_c),
        .opd_b (res_b),
        .res_y (diff_cb)
    );

    // minus d2 gives the third digit
    rrc_eac_unit #(.W(WB), .OP(EAC_SUB)) u_sub_d2 (
        .opd_a (diff_cb),
        .opd_b (fold_d2),
        .res_y (mix_d3)
    );

endmodule

// File: rtl/rrc_recombine.sv
// X = d1 + 2^(2N) d2 + 2^(2N)(2^(2N+1)-1) d3
//   = {d3, d2, d1} - (d3 << 2N)
module rrc_recombine
    import rrc_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [2*N-1:0] res_b,
    input  logic [2*N:0]   mix_d2,
    input  logic [2*N-1:0] mix_d3,
    output logic [6*N:0]   x_out
);
    localparam int WO = out_w(N);
    localparam int WB = narrow_w(N);
    localparam int WA = wide_w(N);

    logic [WO-1:0] packed_sum;
    logic [WO-1:0] corr_term;

    // fields occupy disjoint bit ranges: no adder needed to join them
    assign packed_sum = {mix_d3, mix_d2, res_b};
    assign corr_term  = {{WA{1'b0}}, mix_d3, {WB{1'b0}}};
    // single carry-propagate subtraction; result is never negative
    assign x_out      = packed_sum - corr_term;

endmodule

// File: rtl/rrc_reverse_conv.sv
module rrc_reverse_conv
    import rrc_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [2*N:0]   res_a,
    input  logic [2*N-1:0] res_b,
    input  logic [2*N-1:0] res_c,
    output logic [6*N:0]   x_out
);
    logic [2*N:0]   mix_d2;
    logic [2*N-1:0] mix_d3;

    rrc_digit_stage #(.N(N)) u_digits (
        .res_a  (res_a),
        .res_b  (res_b),
        .res_c  (res_c),
        .mix_d2 (mix_d2),
        .mix_d3 (mix_d3)
    );

    rrc_recombine #(.N(N)) u_recomb (
        .res_b  (res_b),
        .mix_d2 (mix_d2),
        .mix_d3 (mix_d3),
        .x_out  (x_out)
    );

endmodule

// File: rtl/rrc_reverse_conv_chk.sv
module rrc_reverse_conv_chk #(
    parameter int N = 4
) (
    input logic [2*N:0]   res_a,
    input logic [2*N-1:0] res_b,
    input logic [2*N-1:0] res_c,
    input logic [6*N:0]   x_out,
    input logic [2*N:0]   mix_d2,
    input logic [2*N-1:0] mix_d3
);
    localparam longint MA = (longint'(1) << (2 * N + 1)) - 1;
    localparam longint MB = longint'(1) << (2 * N);
    localparam longint MC = (longint'(1) << (2 * N)) - 1;
    localparam longint MT = MA * MB * MC;

    always_comb begin
        // R3
        range_chk: assert (longint'(x_out) < MT);
        // R2
        low_bits_chk: assert (x_out[2*N-1:0] == res_b);
        // R4
        mod_a_chk: assert ((longint'(x_out) % MA) == (longint'(res_a) % MA));
        // R5
        mod_c_chk: assert ((longint'(x_out) % MC) == (longint'(res_c) % MC));
        // R3
        digit2_norm_chk: assert (mix_d2 != '1);
        // R3
        digit3_norm_chk: assert (mix_d3 != '1);
    end

endmodule

bind rrc_reverse_conv rrc_reverse_conv_chk #(.N(N)) u_chk (
    .res_a  (res_a),
    .res_b  (res_b),
    .res_c  (res_c),
    .x_out  (x_out),
    .mix_d2 (mix_d2),
    .mix_d3 (mix_d3)
);

// File: tb/rrc_reverse_conv_bench.sv
module rrc_reverse_conv_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // n = 1
    logic [2:0]  a1 = '0;
    logic [1:0]  b1 = '0, c1 = '0;
    logic [6:0]  y1;
    // n = 2
    logic [4:0]  a2 = '0;
    logic [3:0]  b2 = '0, c2 = '0;
    logic [12:0] y2;
    // n = 3
    logic [6:0]  a3 = '0;
    logic [5:0]  b3 = '0, c3 = '0;
    logic [18:0] y3;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    rrc_reverse_conv #(.N(1)) u_rrc_reverse_conv_n1 (.res_a(a1), .res_b(b1), .res_c(c1), .x_out(y1));
    rrc_reverse_conv #(.N(2)) u_rrc_reverse_conv_n2 (.res_a(a2), .res_b(b2), .res_c(c2), .x_out(y2));
    rrc_reverse_conv #(.N(3)) u_rrc_reverse_conv    (.res_a(a3), .res_b(b3), .res_c(c3), .x_out(y3));

    function automatic longint mod_a(input int n);
        return (longint'(1) << (2 * n + 1)) - 1;
    endfunction
    function automatic longint mod_b(input int n);
        return longint'(1) << (2 * n);
    endfunction
    function automatic longint mod_c(input int n);
        return (longint'(1) << (2 * n)) - 1;
    endfunction
    function automatic longint range_m(input int n);
        return mod_a(n) * mod_b(n) * mod_c(n);
    endfunction

    function automatic longint got(input int n);
        case (n)
            1:       return longint'(y1);
            2:       return longint'(y2);
            default: return longint'(y3);
        endcase
    endfunction

    task automatic set_in(input int n, input longint ra, input longint rb, input longint rc);
        case (n)
            1: begin a1 = ra[2:0]; b1 = rb[1:0]; c1 = rc[1:0]; end
            2: begin a2 = ra[4:0]; b2 = rb[3:0]; c2 = rc[3:0]; end
            default: begin a3 = ra[6:0]; b3 = rb[5:0]; c3 = rc[5:0]; end
        endcase
    endtask

    // drive just after a rising edge, sample on the falling edge
    task automatic apply(input int n, input longint ra, input longint rb, input longint rc);
        @(posedge clk);
        #1;
        set_in(n, ra, rb, rc);
        @(negedge clk);
    endtask

    task automatic expect_val(input string req, input int n, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s n=%0d: actual %0d expected %0d", req, n, act, exp);
        end
    endtask

    task automatic check_x(input string req, input int n, input longint x);
        apply(n, x % mod_a(n), x % mod_b(n), x % mod_c(n));
        expect_val(req, n, got(n), x);
    endtask

    task automatic t_reset_state();
        expect_val("R6", 1, got(1), 0);
        expect_val("R6", 2, got(2), 0);
        expect_val("R6", 3, got(3), 0);
    endtask

    task automatic t_zero_and_max();
        for (int n = 1; n <= 3; n++) begin
            apply(n, 0, 0, 0);
            expect_val("R6", n, got(n), 0);
            apply(n, mod_a(n) - 1, mod_b(n) - 1, mod_c(n) - 1);
            expect_val("R7", n, got(n), range_m(n) - 1);
        end
    endtask

    task automatic t_exhaustive_n1();
        for (longint x = 0; x < range_m(1); x++) begin
            check_x("R1", 1, x);
            expect_val("R3", 1, longint'(got(1) < range_m(1)), 1);
        end
    endtask

    task automatic t_boundaries();
        for (int n = 2; n <= 3; n++) begin
            check_x("R1", n, mod_b(n) - 1);
            check_x("R1", n, mod_b(n));
            check_x("R1", n, mod_c(n));
            check_x("R1", n, mod_a(n));
            check_x("R1", n, mod_a(n) * mod_b(n));
            check_x("R1", n, mod_b(n) * mod_c(n));
            check_x("R1", n, mod_a(n) * mod_c(n));
            check_x("R1", n, range_m(n) - mod_b(n));
            check_x("R1", n, range_m(n) - 2);
        end
    endtask

    task automatic t_low_bits();
        for (int k = 0; k < 40; k++) begin
            longint ra, rb, rc;
            ra = longint'($urandom) % (mod_a(3) + 1);
            rb = longint'($urandom) % mod_b(3);
            rc = longint'($urandom) % (mod_c(3) + 1);
            apply(3, ra, rb, rc);
            expect_val("R2", 3, got(3) % mod_b(3), rb);
            expect_val("R3", 3, longint'(got(3) < range_m(3)), 1);
        end
    endtask

    // alias on res_a while both digit subtractions wrap (large res_b)
    task automatic t_alias_a();
        for (int n = 1; n <= 3; n++) begin
            for (int k = 0; k < 6; k++) begin
                longint rb, rc, ref_y;
                rb = mod_b(n) - 1 - (longint'(k) % mod_b(n));
                rc = longint'($urandom) % mod_c(n);
                apply(n, 0, rb, rc);
                ref_y = got(n);
                apply(n, mod_a(n), rb, rc);
                expect_val("R4", n, got(n), ref_y);
                expect_val("R3", n, longint'(got(n) < range_m(n)), 1);
            end
        end
    endtask

    task automatic t_alias_c();
        for (int n = 1; n <= 3; n++) begin
            for (int k = 0; k < 6; k++) begin
                longint ra, rb, ref_y;
                ra = longint'($urandom) % mod_a(n);
                rb = mod_b(n) - 1 - (longint'(k) % mod_b(n));
                apply(n, ra, rb, 0);
                ref_y = got(n);
                apply(n, ra, rb, mod_c(n));
                expect_val("R5", n, got(n), ref_y);
                expect_val("R2", n, got(n) % mod_b(n), rb);
            end
        end
    endtask

    task automatic t_random();
        for (int n = 2; n <= 3; n++) begin
            for (int k = 0; k < 200; k++) begin
                check_x("R1", n, longint'($urandom) % range_m(n));
            end
        end
    endtask

    // R8: no clock edge between input change and sample
    task automatic t_comb();
        longint xs [4] = '{1000, 77, 511999, 64};
        @(posedge clk);
        #1;
        for (int k = 0; k < 4; k++) begin
            set_in(3, xs[k] % mod_a(3), xs[k] % mod_b(3), xs[k] % mod_c(3));
            #1;
            expect_val("R8", 3, got(3), xs[k]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_zero_and_max();
        t_exhaustive_n1();
        t_boundaries();
        t_low_bits();
        t_alias_a();
        t_alias_c();
        t_random();
        t_comb();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule